// File: doc/BRIEF.md
# Double-Buffered Raster Timing Generator

This block generates the horizontal and vertical sync, the data-enable window and a one-cycle fetch-start pulse for a display pipeline. The same pulse also clears the pixel FIFO. Every timing field and the fetch-control fields exist twice. Software writes a pending copy through a simple write and read port. The raster runs from an active copy, which software cannot reach directly.

To commit the pending copy, software sets a request bit. The hardware waits for one defined point in vertical blanking, copies the whole pending set into the active set at that point, and clears the request bit. The request bit reading back as zero is therefore the only completion indicator. For example, a disable written to the pending enable reads back at once, but the raster keeps producing data-enable until the transfer. A fetch-start option selects the raster position at which the pulse fires and the transfer takes place.

The block also watches a FIFO-empty input during the data-enable window and records any underrun in a sticky status bit. Software clears that bit by writing one to it.

Top module: `disp_timing_shadow`

## Requirements
- R1: After reset, hsync, vsync, de and fetch_strobe are low, and every register (addresses 0 to 5) reads zero.
- R2: Register map, with every read returning the pending copy:
  - Address 0 holds the enable in bit 0, the fetch-start option in bits 9:8 and the request in bit 31.
  - Address 1 holds the horizontal active width in bits 12:0 and the front porch in bits 28:16.
  - Address 2 holds the hsync width in bits 12:0 and the back porch in bits 28:16.
  - Address 3 holds the vertical active height in bits 11:0 and the front porch in bits 27:16.
  - Address 4 holds the vsync width in bits 11:0 and the back porch in bits 27:16.
  - Address 5 holds the underrun flag in bit 0.
- R3: A write to address 0 with bit 31 set raises the request. A write with bit 31 clear leaves the request unchanged. The request stays set until the transfer.
- R4: With valid active timing, the transfer happens on the clock edge after the cycle in which the raster is at the option's point. After that edge, the request reads zero. The points are:
  - Option 0: pixel column equal to the active width, on the last active line (the first blank pixel after the final active pixel).
  - Option 1: column 0 of the first vsync line.
  - Option 2: column 0 of the first back-porch line.
  - Option 3: column 0 of the last line of the frame.
- R5: While the active timing is invalid, a pending request is taken on the very next clock edge.
- R6: Counters start at column 0 and line 0. With line length L = active+front+sync+back and frame height F likewise, the column runs 0..L-1 and the line advances when the column wraps. hsync is high for columns from active+front up to, but not including, active+front+sync. vsync follows the same rule on lines. de is high when both the column and the line are inside their active ranges.
- R7: When the active enable is low, de and fetch_strobe stay low while hsync and vsync keep running.
- R8: When the active enable is high, fetch_strobe is a one-cycle pulse in each cycle the raster sits at the option's point.
- R9: The underrun flag is set by any cycle with de and fifo_empty both high. Writing address 5 with bit 0 set clears it. A set in the same cycle as a clear wins. Writing 0 to bit 0 has no effect.
- R10: Pending writes made while a request is outstanding are carried by that request's transfer.
- R11: Active timing is valid only when horizontal active, hsync width, vertical active, vsync width and vertical back porch are all nonzero. Otherwise all four outputs stay low and the counters stay at zero.
- R12: A 4400-clock line with 3840 active pixels, an 88-clock hsync and a 296-clock back porch, on a frame of 2160 active lines with a 10-line vsync and a 72-line back porch, is produced correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| fifo_empty | input | 1 | Pixel FIFO has no data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active pixel window |
| fetch_strobe | output | 1 | Start-of-fetch and FIFO-clear pulse |

## Verification
The hardest case to reach from the ports is an enable change that a transfer has not yet applied. Here the pending enable already reads low while de is still toggling, and the request must then clear at the exact column and line chosen by the active option rather than the pending one. The bench reaches this case by writing new timing and a new option while a request is outstanding, from random raster positions. It also re-arms requests with random timing sets, including deliberately invalid ones that must load immediately. A cycle-level model of the raster is compared with the outputs on every cycle, and the request bit is polled on every cycle of each wait.

// File: rtl/disp_timing_shadow.sv
`timescale 1ns/1ps
module disp_timing_shadow #(
  parameter int HW = 13,
  parameter int VW = 12,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          fifo_empty,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          fetch_strobe
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_HLO  = AW'(1);
  localparam logic [AW-1:0] A_HHI  = AW'(2);
  localparam logic [AW-1:0] A_VLO  = AW'(3);
  localparam logic [AW-1:0] A_VHI  = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);
  localparam int UP = 16;
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  typedef struct packed {
    logic          en;
    logic [1:0]    opt;
    logic [HW-1:0] ha, hf, hs, hb;
    logic [VW-1:0] va, vf, vs, vb;
  } tset_t;

  tset_t pend, act;
  logic req, und;
  logic [HW-1:0] hc;
  logic [VW-1:0] vc;

  logic wr_ctrl, clr_und, tim_ok, at_point, load;
  logic [HW-1:0] hs_beg, hs_end, h_tot, pt_h;
  logic [VW-1:0] vs_beg, vs_end, v_tot, pt_v;

  assign wr_ctrl = wr_en && wr_addr == A_CTRL;
  assign clr_und = wr_en && wr_addr == A_STAT && wr_data[0];

  assign hs_beg = act.ha + act.hf;
  assign hs_end = hs_beg + act.hs;
  assign h_tot  = hs_end + act.hb;
  assign vs_beg = act.va + act.vf;
  assign vs_end = vs_beg + act.vs;
  assign v_tot  = vs_end + act.vb;
  assign tim_ok = |act.ha && |act.hs && |act.va && |act.vs && |act.vb;

  always_comb begin
    case (act.opt)
      2'd0:    pt_v = act.va - V_ONE;
      2'd1:    pt_v = vs_beg;
      2'd2:    pt_v = vs_end;
      default: pt_v = v_tot - V_ONE;
    endcase
  end
  assign pt_h     = (act.opt == 2'd0) ? act.ha : '0;
  assign at_point = tim_ok && hc == pt_h && vc == pt_v;
  assign load     = req && (at_point || !tim_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin pend.en <= wr_data[0]; pend.opt <= wr_data[9:8]; end
        A_HLO:  begin pend.ha <= wr_data[HW-1:0]; pend.hf <= wr_data[UP+:HW]; end
        A_HHI:  begin pend.hs <= wr_data[HW-1:0]; pend.hb <= wr_data[UP+:HW]; end
        A_VLO:  begin pend.va <= wr_data[VW-1:0]; pend.vf <= wr_data[UP+:VW]; end
        A_VHI:  begin pend.vs <= wr_data[VW-1:0]; pend.vb <= wr_data[UP+:VW]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      req <= 1'b0;
      und <= 1'b0;
    end else begin
      if (load) act <= pend;
      if (wr_ctrl && wr_data[DW-1]) req <= 1'b1;
      else if (load)                 req <= 1'b0;
      if (de && fifo_empty) und <= 1'b1;
      else if (clr_und)     und <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (!tim_ok) begin
      hc <= '0;
      vc <= '0;
    end else if (hc >= h_tot - H_ONE) begin
      hc <= '0;
      vc <= (vc >= v_tot - V_ONE) ? '0 : vc + V_ONE;
    end else begin
      hc <= hc + H_ONE;
    end
  end

  assign hsync        = tim_ok && hc >= hs_beg && hc < hs_end;
  assign vsync        = tim_ok && vc >= vs_beg && vc < vs_end;
  assign de           = act.en && tim_ok && hc < act.ha && vc < act.va;
  assign fetch_strobe = act.en && at_point;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin rd_data[0] = pend.en; rd_data[9:8] = pend.opt; rd_data[DW-1] = req; end
      A_HLO:  begin rd_data[HW-1:0] = pend.ha; rd_data[UP+:HW] = pend.hf; end
      A_HHI:  begin rd_data[HW-1:0] = pend.hs; rd_data[UP+:HW] = pend.hb; end
      A_VLO:  begin rd_data[VW-1:0] = pend.va; rd_data[UP+:VW] = pend.vf; end
      A_VHI:  begin rd_data[VW-1:0] = pend.vs; rd_data[UP+:VW] = pend.vb; end
      A_STAT: rd_data[0] = und;
      default: ;
    endcase
  end

  AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n) de |-> !hsync && !vsync); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fetch_strobe |=> !fetch_strobe); // R8
  AST_REQ_CLEAR_POINT: assert property (@(posedge clk) disable iff (!rst_n) $fell(req) |-> $past(at_point || !tim_ok)); // R4
  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !$past(load) |-> $stable(act)); // R10
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(und) && !$past(clr_und) |-> und); // R9
endmodule

// File: tb/disp_timing_shadow_test.sv
`timescale 1ns/1ps
module disp_timing_shadow_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, fifo_empty = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic hsync, vsync, de, fetch_strobe;

  disp_timing_shadow uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .hsync(hsync), .vsync(vsync), .de(de), .fetch_strobe(fetch_strobe));

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic en; logic [1:0] opt;
    logic [12:0] ha, hf, hs, hb;
    logic [11:0] va, vf, vs, vb;
  } mset_t;

  mset_t mp, ma;
  logic m_req, m_und;
  logic [12:0] m_hc;
  logic [11:0] m_vc;

  int vecs = 0, miss = 0, cyc_vec = 0, cyc_miss = 0;
  logic mon_on = 1'b0, rnd_empty = 1'b0, done = 1'b0;
  string cur_tag = "R6";

  function automatic logic [12:0] e_htot(); return ma.ha + ma.hf + ma.hs + ma.hb; endfunction
  function automatic logic [11:0] e_vtot(); return ma.va + ma.vf + ma.vs + ma.vb; endfunction
  function automatic logic e_ok(); return ma.ha != 0 && ma.hs != 0 && ma.va != 0 && ma.vs != 0 && ma.vb != 0; endfunction
  function automatic logic e_point();
    logic [12:0] ph; logic [11:0] pv;
    ph = (ma.opt == 2'd0) ? ma.ha : 13'd0;
    case (ma.opt)
      2'd0: pv = ma.va - 12'd1;
      2'd1: pv = ma.va + ma.vf;
      2'd2: pv = ma.va + ma.vf + ma.vs;
      default: pv = e_vtot() - 12'd1;
    endcase
    return e_ok() && m_hc == ph && m_vc == pv;
  endfunction
  function automatic logic e_hs(); return e_ok() && m_hc >= ma.ha + ma.hf && m_hc < ma.ha + ma.hf + ma.hs; endfunction
  function automatic logic e_vs(); return e_ok() && m_vc >= ma.va + ma.vf && m_vc < ma.va + ma.vf + ma.vs; endfunction
  function automatic logic e_de(); return ma.en && e_ok() && m_hc < ma.ha && m_vc < ma.va; endfunction
  function automatic logic [31:0] e_read(input logic [2:0] a);
    logic [31:0] r; r = '0;
    case (a)
      3'd0: begin r[0] = mp.en; r[9:8] = mp.opt; r[31] = m_req; end
      3'd1: begin r[12:0] = mp.ha; r[28:16] = mp.hf; end
      3'd2: begin r[12:0] = mp.hs; r[28:16] = mp.hb; end
      3'd3: begin r[11:0] = mp.va; r[27:16] = mp.vf; end
      3'd4: begin r[11:0] = mp.vs; r[27:16] = mp.vb; end
      3'd5: r[0] = m_und;
      default: ;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp <= '0; ma <= '0; m_req <= 1'b0; m_und <= 1'b0; m_hc <= '0; m_vc <= '0;
    end else begin
      if (wr_en) case (wr_addr)
        3'd0: begin mp.en <= wr_data[0]; mp.opt <= wr_data[9:8]; end
        3'd1: begin mp.ha <= wr_data[12:0]; mp.hf <= wr_data[28:16]; end
        3'd2: begin mp.hs <= wr_data[12:0]; mp.hb <= wr_data[28:16]; end
        3'd3: begin mp.va <= wr_data[11:0]; mp.vf <= wr_data[27:16]; end
        3'd4: begin mp.vs <= wr_data[11:0]; mp.vb <= wr_data[27:16]; end
        default: ;
      endcase
      if (m_req && (e_point() || !e_ok())) ma <= mp;
      if (wr_en && wr_addr == 3'd0 && wr_data[31]) m_req <= 1'b1;
      else if (m_req && (e_point() || !e_ok())) m_req <= 1'b0;
      if (e_de() && fifo_empty) m_und <= 1'b1;
      else if (wr_en && wr_addr == 3'd5 && wr_data[0]) m_und <= 1'b0;
      if (!e_ok()) begin m_hc <= '0; m_vc <= '0; end
      else if (m_hc >= e_htot() - 13'd1) begin
        m_hc <= '0;
        m_vc <= (m_vc >= e_vtot() - 12'd1) ? 12'd0 : m_vc + 12'd1;
      end else m_hc <= m_hc + 13'd1;
    end
  end

  // raster compare every cycle: hsync/vsync R6, de R7, fetch_strobe R8 (tag set per phase)
  always @(negedge clk) begin
    if (mon_on) begin
      cyc_vec++;
      if ({hsync, vsync, de, fetch_strobe} !== {e_hs(), e_vs(), e_de(), e_point() && ma.en}) begin
        cyc_miss++;
        $display("FAIL %s raster hs/vs/de/fs: got %b expected %b", cur_tag,
                 {hsync, vsync, de, fetch_strobe}, {e_hs(), e_vs(), e_de(), e_point() && ma.en});
      end
    end
  end

  always @(negedge clk) if (rnd_empty) fifo_empty <= $urandom % 4 == 0;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag, input string what);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    @(negedge clk); rd_addr = a; #1;
    chk(rd_data, e_read(a), tag, "register read");
  endtask

  task automatic prog(input int ha, hf, hs, hb, va, vf, vs, vb);
    wr(3'd1, 32'(ha) | (32'(hf) << 16));
    wr(3'd2, 32'(hs) | (32'(hb) << 16));
    wr(3'd3, 32'(va) | (32'(vf) << 16));
    wr(3'd4, 32'(vs) | (32'(vb) << 16));
  endtask

  task automatic wait_clear(input string tag);
    for (int n = 0; n < 6000; n++) begin
      rd_chk(3'd0, tag);
      if (!rd_data[31]) return;
    end
    chk(32'(rd_data[31]), 32'd0, tag, "request never cleared");
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs + cyc_vec, miss + cyc_miss);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic dummy;
    dummy = 1'($urandom(32'd51729));
    mon_on = 1'b1;
    cur_tag = "R1";
    idle(3);
    for (int a = 0; a < 6; a++) rd_chk(3'(a), "R1");
    rst_n = 1'b1;
    idle(2);

    cur_tag = "R5";
    prog(8, 2, 3, 4, 4, 1, 2, 2);
    wr(3'd0, 32'h8000_0001);
    rd_chk(3'd0, "R5");
    chk(32'(rd_data[31]), 32'd0, "R5", "immediate load with invalid timing");
    for (int a = 1; a < 5; a++) rd_chk(3'(a), "R2");
    cur_tag = "R6"; idle(400);

    wr(3'd0, 32'h0000_0000);
    rd_chk(3'd0, "R2");
    chk(32'(rd_data[0]), 32'd0, "R2", "pending enable reads low at once");
    begin
      int seen = 0;
      for (int n = 0; n < 160; n++) begin @(negedge clk); if (de) seen++; end
      chk(32'(seen != 0), 32'd1, "R2", "de still running before transfer");
    end

    wr(3'd0, 32'h8000_0000);
    rd_chk(3'd0, "R3");
    wr(3'd0, 32'h0000_0100);
    rd_chk(3'd0, "R3");
    chk(32'(rd_data[31]), 32'd1, "R3", "write without bit 31 keeps request");
    wr(3'd1, 32'(10) | (32'(3) << 16));
    cur_tag = "R10";
    wait_clear("R4");
    cur_tag = "R7"; idle(400);

    cur_tag = "R8";
    for (int o = 0; o < 4; o++) begin
      wr(3'd0, 32'h8000_0001 | (32'(o) << 8));
      wait_clear("R4");
      idle(350);
    end

    cur_tag = "R9";
    rd_chk(3'd5, "R9");
    fifo_empty = 1'b1; idle(200); fifo_empty = 1'b0;
    rd_chk(3'd5, "R9");
    chk(rd_data, 32'd1, "R9", "underrun flag set");
    wr(3'd5, 32'd0);
    rd_chk(3'd5, "R9");
    wr(3'd5, 32'd1);
    rd_chk(3'd5, "R9");
    chk(rd_data, 32'd0, "R9", "underrun flag cleared by write one");

    cur_tag = "R11";
    prog(8, 2, 3, 4, 4, 1, 2, 0);
    wr(3'd0, 32'h8000_0001);
    wait_clear("R11");
    idle(50);
    chk(32'({hsync, vsync, de}), 32'd0, "R11", "outputs quiet on invalid timing");
    prog(6, 1, 2, 3, 3, 1, 1, 1);
    wr(3'd0, 32'h8000_0201);
    rd_chk(3'd0, "R5");
    chk(32'(rd_data[31]), 32'd0, "R5", "request taken next edge");
    idle(200);

    cur_tag = "R6";
    rnd_empty = 1'b1;
    for (int i = 0; i < 28; i++) begin
      prog(1 + $urandom % 12, $urandom % 4, 1 + $urandom % 4, $urandom % 5,
           1 + $urandom % 6, $urandom % 3, 1 + $urandom % 3, (i % 7 == 3) ? 0 : 1 + $urandom % 3);
      wr(3'd0, 32'h8000_0000 | (32'($urandom % 4) << 8) | 32'($urandom % 4 != 0));
      if ($urandom % 2 == 1) wr(3'd1, 32'(2 + $urandom % 9) | (32'($urandom % 3) << 16));
      wait_clear("R4");
      rd_chk(3'd5, "R9");
      if ($urandom % 3 == 0) wr(3'd5, 32'd1);
      idle(100 + $urandom % 400);
    end
    rnd_empty = 1'b0; fifo_empty = 1'b0;

    cur_tag = "R12";
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    prog(3840, 176, 88, 296, 2160, 8, 10, 72);
    wr(3'd0, 32'h8000_0001);
    for (int a = 0; a < 5; a++) rd_chk(3'(a), "R12");
    begin
      int hs_cnt = 0;
      for (int n = 0; n < 9000; n++) begin
        @(negedge clk);
        if (n >= 4400 && n < 8800 && hsync) hs_cnt++;
      end
      chk(32'(hs_cnt), 32'd88, "R12", "hsync width over one line");
    end

    done = 1'b1;
    summary();
  end
endmodule